// File: doc/BRIEF.md
# Configurable IRQ/FIQ Interrupt Controller

This block collects up to sixteen interrupt request lines and turns them into two processor-facing signals: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Each line passes through a two-flop synchroniser. It is then corrected for polarity and, where the line is configured that way, reduced to an edge event. The result sits in a pending latch. Two independent enable masks select which pending requests feed each output, and software can read the masked views and the raw pending vector.

Software uses the block through a small word-addressed register port. Writes take effect on the clock edge at which `bus_sel` and `bus_we` are both high. Read data is combinational from `bus_waddr`. Software first sets the trigger and polarity of each line. It then clears any stale latched events and enables the lines it services. In its handler it reads a status word and writes ones to the clear word for the edge events it has served.

Registers are selected by word index (byte offset divided by four):
- 0: `CFG_DUAL`, the two-bit line settings.
- 1: `CFG_POL`, the polarity-only bits.
- 2: `CLEAR`.
- 3: `IRQ_EN`.
- 4: `FIQ_EN`.
- 5: `IRQ_STAT`.
- 6: `FIQ_STAT`.
- 7: `PENDING`.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After reset, `CFG_DUAL`, `CFG_POL`, `IRQ_EN` and `FIQ_EN` read 0, and `irq_o` and `fiq_o` are low. With these settings, lines 0 to 8 are active-low and level-triggered.
- R2: In `CFG_DUAL` (index 0), line n (0 to 5) uses two bits. Bit 2n selects polarity (1 = active high, 0 = active low). Bit 2n+1 selects the trigger (1 = edge, 0 = level). An active-low edge line latches on a falling input.
- R3: In `CFG_POL` (index 1), bit k sets the polarity of line 6+k (k = 0..2), using the same encoding as R2. These lines are always level-triggered. Lines 9 to 15 are fixed as active-high and level-triggered.
- R4: An input change made before clock edge k first shows in `PENDING` after edge k+2. Edge k loads the first synchroniser flop, edge k+1 the second, and edge k+2 the pending latch.
- R5: An edge-triggered line sets its pending bit on the inactive-to-active transition of its corrected input. The bit stays set after the input returns to its inactive level.
- R6: Writing `CLEAR` (index 2) with bit n = 1 clears the pending bit of edge line n, and bits written as 0 leave their lines unchanged. `CLEAR` reads as 0. If a new edge arrives in the same cycle as a clear, the edge wins.
- R7: The pending bit of a level-triggered line follows its corrected input. A `CLEAR` write does not change it.
- R8: `IRQ_STAT` (index 5) reads PENDING AND `IRQ_EN`, and `FIQ_STAT` (index 6) reads PENDING AND `FIQ_EN`. `IRQ_EN` (index 3) and `FIQ_EN` (index 4) read back the value written, and an enable value of 0 masks every line.
- R9: `irq_o` is the OR of the `IRQ_STAT` bits, and `fiq_o` is the OR of the `FIQ_STAT` bits. Each output is registered, so it changes one clock edge after the status it reflects.
- R10: `PENDING` (index 7) reads the raw pending vector whatever the enable values are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_LINES | Asynchronous interrupt request lines |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high together with bus_sel |
| bus_waddr | input | 3 | Register word index |
| bus_wdata | input | N_LINES | Write data |
| bus_rdata | output | N_LINES | Read data, combinational from bus_waddr |
| irq_o | output | 1 | Registered OR of the IRQ status bits |
| fiq_o | output | 1 | Registered OR of the FIQ status bits |

## Verification
A corrupted pending bit becomes visible in `PENDING` right after the clock edge that stores it. Through `irq_o` or `fiq_o` it shows one edge later, but only if the line is enabled there. An edge latch that drops early, or a clear that also removes neighbouring lines, therefore shows at the very next register read. A wrong polarity or trigger decode shows as a pending bit that is set while the line is idle, or that fails to set two edges after the line becomes active. A mis-timed output register shows as `irq_o` or `fiq_o` changing in the same cycle as an enable write instead of one edge after it.

// File: rtl/ifc_pkg.sv
// Shared constants for the IRQ/FIQ interrupt controller.
// Assumes a word-indexed register port; indices equal byte offset / 4.
package ifc_pkg;
    localparam int IDX_W = 3;
    localparam logic [IDX_W-1:0] IDX_CFG_DUAL = 3'd0;
    localparam logic [IDX_W-1:0] IDX_CFG_POL  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_CLEAR    = 3'd2;
    localparam logic [IDX_W-1:0] IDX_IRQ_EN   = 3'd3;
    localparam logic [IDX_W-1:0] IDX_FIQ_EN   = 3'd4;
    localparam logic [IDX_W-1:0] IDX_IRQ_STAT = 3'd5;
    localparam logic [IDX_W-1:0] IDX_FIQ_STAT = 3'd6;
    localparam logic [IDX_W-1:0] IDX_PENDING  = 3'd7;
endpackage

// File: rtl/ifc_sync_cond.sv
// Per-line input conditioning: two-flop synchroniser, polarity correction
// and inactive-to-active edge detection.
// Assumes req_i is asynchronous; the synchroniser and history flops carry
// no reset and simply track the input, also while reset is asserted.
module ifc_sync_cond #(
    parameter int N_LINES = 16
) (
    input  logic               clk,
    input  logic [N_LINES-1:0] req_i,
    input  logic [N_LINES-1:0] pol_i,
    output logic [N_LINES-1:0] corr_o,
    output logic [N_LINES-1:0] rise_o
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic meta_q;
        logic sync_q;
        logic hist_q;

        // Two-stage synchroniser for one request line.
        always_ff @(posedge clk) begin
            meta_q <= req_i[i];
            sync_q <= meta_q;
        end

        // Polarity correction: active level becomes 1.
        always_comb corr_o[i] = sync_q ~^ pol_i[i];

        // Remember the previous corrected level for edge detection.
        always_ff @(posedge clk) hist_q <= corr_o[i];

        // Inactive-to-active transition of the corrected level.
        always_comb rise_o[i] = corr_o[i] & ~hist_q;
    end
endmodule

// File: rtl/ifc_regfile.sv
// Register file of the interrupt controller: configuration, clear strobe,
// enable masks and the read multiplexer.
// Assumes N_LINES >= 2*N_DUAL and N_LINES >= N_DUAL + N_POL.
module ifc_regfile
    import ifc_pkg::*;
#(
    parameter int N_LINES = 16,
    parameter int N_DUAL  = 6,
    parameter int N_POL   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [IDX_W-1:0]   bus_waddr,
    input  logic [N_LINES-1:0] bus_wdata,
    input  logic [N_LINES-1:0] pending_i,
    output logic [N_LINES-1:0] pol_o,
    output logic [N_LINES-1:0] edge_o,
    output logic [N_LINES-1:0] clr_o,
    output logic [N_LINES-1:0] irq_en_o,
    output logic [N_LINES-1:0] fiq_en_o,
    output logic [N_LINES-1:0] rdata_o
);
    localparam int DUAL_W = 2 * N_DUAL;

    logic [DUAL_W-1:0] cfg_dual_q;
    logic [N_POL-1:0]  cfg_pol_q;
    logic              wr_hit;

    always_comb wr_hit = bus_sel & bus_we;

    // Configuration and enable registers, written on a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_dual_q <= '0;
            cfg_pol_q  <= '0;
            irq_en_o   <= '0;
            fiq_en_o   <= '0;
        end else if (wr_hit) begin
            case (bus_waddr)
                IDX_CFG_DUAL: cfg_dual_q <= bus_wdata[DUAL_W-1:0];
                IDX_CFG_POL:  cfg_pol_q  <= bus_wdata[N_POL-1:0];
                IDX_IRQ_EN:   irq_en_o   <= bus_wdata;
                IDX_FIQ_EN:   fiq_en_o   <= bus_wdata;
                default: ;
            endcase
        end
    end

    // One-cycle clear strobe, active only during a clear write.
    always_comb clr_o = (wr_hit && bus_waddr == IDX_CLEAR) ? bus_wdata : '0;

    // Decode per-line polarity and trigger selection.
    for (genvar i = 0; i < N_LINES; i++) begin : g_cfg
        if (i < N_DUAL) begin : g_dual
            always_comb begin
                pol_o[i]  = cfg_dual_q[2*i];
                edge_o[i] = cfg_dual_q[2*i+1];
            end
        end else if (i < N_DUAL + N_POL) begin : g_pol
            always_comb begin
                pol_o[i]  = cfg_pol_q[i-N_DUAL];
                edge_o[i] = 1'b0;
            end
        end else begin : g_fixed
            always_comb begin
                pol_o[i]  = 1'b1;
                edge_o[i] = 1'b0;
            end
        end
    end

    // Read multiplexer, combinational from the word index.
    always_comb begin
        rdata_o = '0;
        case (bus_waddr)
            IDX_CFG_DUAL: rdata_o[DUAL_W-1:0] = cfg_dual_q;
            IDX_CFG_POL:  rdata_o[N_POL-1:0]  = cfg_pol_q;
            IDX_IRQ_EN:   rdata_o = irq_en_o;
            IDX_FIQ_EN:   rdata_o = fiq_en_o;
            IDX_IRQ_STAT: rdata_o = pending_i & irq_en_o;
            IDX_FIQ_STAT: rdata_o = pending_i & fiq_en_o;
            IDX_PENDING:  rdata_o = pending_i;
            default:      rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/ifc_pending_core.sv
// Pending latch: edge lines set on an event and hold until cleared
// (a new event wins over a same-cycle clear); level lines follow the
// corrected input and ignore the clear strobe.
module ifc_pending_core #(
    parameter int N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] corr_i,
    input  logic [N_LINES-1:0] rise_i,
    input  logic [N_LINES-1:0] edge_i,
    input  logic [N_LINES-1:0] clr_i,
    output logic [N_LINES-1:0] pending_o
);
    logic [N_LINES-1:0] pend_nxt;

    // Next pending state per trigger type.
    always_comb pend_nxt = (edge_i & (rise_i | (pending_o & ~clr_i)))
                         | (~edge_i & corr_i);

    // Pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_o <= '0;
        else        pending_o <= pend_nxt;
    end
endmodule

// File: rtl/irq_fiq_ctrl.sv
// Top of the IRQ/FIQ interrupt controller: conditioning, pending latch,
// register file and registered aggregate outputs.
// Assumes synchronous active-low reset and a single clock domain for the bus.
module irq_fiq_ctrl
    import ifc_pkg::*;
#(
    parameter int N_LINES = 16,
    parameter int N_DUAL  = 6,
    parameter int N_POL   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [IDX_W-1:0]   bus_waddr,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    logic [N_LINES-1:0] pol_sel;
    logic [N_LINES-1:0] edge_sel;
    logic [N_LINES-1:0] clr_mask;
    logic [N_LINES-1:0] irq_en;
    logic [N_LINES-1:0] fiq_en;
    logic [N_LINES-1:0] corr;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] pending;

    ifc_sync_cond #(.N_LINES(N_LINES)) u_cond (
        .clk    (clk),
        .req_i  (req_i),
        .pol_i  (pol_sel),
        .corr_o (corr),
        .rise_o (rise)
    );

    ifc_regfile #(.N_LINES(N_LINES), .N_DUAL(N_DUAL), .N_POL(N_POL)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .pending_i (pending),
        .pol_o     (pol_sel),
        .edge_o    (edge_sel),
        .clr_o     (clr_mask),
        .irq_en_o  (irq_en),
        .fiq_en_o  (fiq_en),
        .rdata_o   (bus_rdata)
    );

    ifc_pending_core #(.N_LINES(N_LINES)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .corr_i    (corr),
        .rise_i    (rise),
        .edge_i    (edge_sel),
        .clr_i     (clr_mask),
        .pending_o (pending)
    );

    // Registered aggregate interrupt outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |(pending & irq_en);
            fiq_o <= |(pending & fiq_en);
        end
    end
endmodule

// File: rtl/ifc_chk.sv
// Assertion checker for irq_fiq_ctrl, attached by bind below.
module ifc_chk
    import ifc_pkg::*;
#(
    parameter int N_LINES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [N_LINES-1:0] pending,
    input logic [N_LINES-1:0] irq_en,
    input logic [N_LINES-1:0] fiq_en,
    input logic [N_LINES-1:0] clr_mask,
    input logic [N_LINES-1:0] edge_sel,
    input logic [N_LINES-1:0] corr,
    input logic [N_LINES-1:0] rise,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [IDX_W-1:0]   bus_waddr,
    input logic [N_LINES-1:0] bus_wdata
);
    // R9
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_o == $past(|(pending & irq_en))));

    // R9
    fiq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fiq_o == $past(|(pending & fiq_en))));

    // R6
    clr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_mask) |=> ((pending & $past(clr_mask & edge_sel & ~rise)) == '0));

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(pending & edge_sel & ~clr_mask) & edge_sel & ~pending) == '0));

    // R7
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((pending ^ $past(corr)) & ~$past(edge_sel)) == '0));

    // R8
    irq_en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_waddr == IDX_IRQ_EN) |=> (irq_en == $past(bus_wdata)));
endmodule

bind irq_fiq_ctrl ifc_chk #(.N_LINES(N_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .pending   (pending),
    .irq_en    (irq_en),
    .fiq_en    (fiq_en),
    .clr_mask  (clr_mask),
    .edge_sel  (edge_sel),
    .corr      (corr),
    .rise      (rise),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_waddr (bus_waddr),
    .bus_wdata (bus_wdata)
);

// File: tb/tb_irq_fiq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_fiq_ctrl;
    localparam int N = 16;
    // Bench line setup: 0,1,5 edge/high; 2 edge/low; 3 level/high; 4 level/low
    localparam logic [15:0] CFG_DUAL_V = 16'h0C6F;
    // Line 6 high, line 7 low, line 8 high
    localparam logic [15:0] CFG_POL_V  = 16'h0005;
    // Inactive levels under that setup: lines 2, 4, 7 idle high
    localparam logic [15:0] IDLE_V     = 16'h0094;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = 16'h01FF;
    logic         bus_sel = 1'b0;
    logic         bus_we = 1'b0;
    logic [2:0]   bus_waddr = 3'd0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         irq_o;
    logic         fiq_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_fiq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input logic [N-1:0] exp);
        bus_waddr = a;
        #0.1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // R1: reset state of registers and outputs
    task automatic t_reset;
        chk_reg("R1 cfg_dual reset", 3'd0, 16'h0000);
        chk_reg("R1 cfg_pol reset", 3'd1, 16'h0000);
        chk_reg("R1 irq_en reset", 3'd3, 16'h0000);
        chk_reg("R1 fiq_en reset", 3'd4, 16'h0000);
        check("R1 irq_o reset", irq_o, 1'b0);
        check("R1 fiq_o reset", fiq_o, 1'b0);
        chk_reg("R1 pending idle active-low level", 3'd7, 16'h0000);
    endtask

    // R2 R3: program the bench line setup; idle inputs leave nothing pending
    task automatic t_setup;
        req_i = IDLE_V;
        wait_cyc(4);
        bus_wr(3'd0, CFG_DUAL_V);
        bus_wr(3'd1, CFG_POL_V);
        wait_cyc(4);
        bus_wr(3'd2, 16'hFFFF);
        wait_cyc(2);
        chk_reg("R2 cfg_dual readback", 3'd0, CFG_DUAL_V);
        chk_reg("R3 cfg_pol readback", 3'd1, CFG_POL_V);
        chk_reg("R2 R3 idle lines not pending", 3'd7, 16'h0000);
    endtask

    // R4 R5 R6: edge latching, latency and selective clear
    task automatic t_edge;
        req_i[1] = 1'b1; wait_cyc(3); req_i[1] = 1'b0;
        wait_cyc(4);
        @(negedge clk); req_i[0] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk_reg("R4 not yet pending after two edges", 3'd7, 16'h0002);
        @(posedge clk); #1;
        chk_reg("R4 pending after third edge", 3'd7, 16'h0003);
        req_i[0] = 1'b0;
        wait_cyc(5);
        chk_reg("R5 edge held after input drops", 3'd7, 16'h0003);
        bus_wr(3'd2, 16'hFFFE);
        chk_reg("R6 zero bit keeps line 0", 3'd7, 16'h0001);
        chk_reg("R6 clear reads zero", 3'd2, 16'h0000);
        bus_wr(3'd2, 16'h0001);
        chk_reg("R6 clear line 0", 3'd7, 16'h0000);
        req_i[2] = 1'b0; wait_cyc(5);
        chk_reg("R2 active-low edge on fall", 3'd7, 16'h0004);
        req_i[2] = 1'b1; wait_cyc(5);
        chk_reg("R5 active-low edge held", 3'd7, 16'h0004);
        bus_wr(3'd2, 16'h0004);
        chk_reg("R6 clear line 2", 3'd7, 16'h0000);
    endtask

    // R7 R3 R2: level lines follow inputs and ignore clear
    task automatic t_level;
        req_i[3] = 1'b1; req_i[6] = 1'b1; req_i[7] = 1'b0; req_i[12] = 1'b1;
        wait_cyc(5);
        chk_reg("R3 R7 level lines active", 3'd7, 16'h10C8);
        bus_wr(3'd2, 16'hFFFF);
        wait_cyc(1);
        chk_reg("R7 clear ignored by level lines", 3'd7, 16'h10C8);
        req_i[4] = 1'b0; wait_cyc(5);
        chk_reg("R2 active-low level line 4", 3'd7, 16'h10D8);
        req_i = IDLE_V; wait_cyc(5);
        chk_reg("R7 level pending follows release", 3'd7, 16'h0000);
    endtask

    // R8 R9 R10: masks, status words and registered outputs
    task automatic t_masks;
        req_i[5] = 1'b1; wait_cyc(3); req_i[5] = 1'b0;
        req_i[6] = 1'b1; wait_cyc(5);
        check("R8 zero enables keep irq_o low", irq_o, 1'b0);
        bus_wr(3'd3, 16'h0020);
        bus_wr(3'd4, 16'h0040);
        wait_cyc(2);
        chk_reg("R8 irq_en readback", 3'd3, 16'h0020);
        chk_reg("R8 fiq_en readback", 3'd4, 16'h0040);
        chk_reg("R8 irq status", 3'd5, 16'h0020);
        chk_reg("R8 fiq status", 3'd6, 16'h0040);
        chk_reg("R10 raw pending", 3'd7, 16'h0060);
        check("R9 irq_o high", irq_o, 1'b1);
        check("R9 fiq_o high", fiq_o, 1'b1);
        bus_wr(3'd3, 16'h0000);
        check("R9 irq_o registered, still high", irq_o, 1'b1);
        @(posedge clk); #1;
        check("R9 irq_o low one edge later", irq_o, 1'b0);
        chk_reg("R8 zero mask irq status", 3'd5, 16'h0000);
        chk_reg("R10 raw pending ignores mask", 3'd7, 16'h0060);
        bus_wr(3'd3, 16'h0040);
        wait_cyc(1);
        check("R9 irq_o from level line", irq_o, 1'b1);
        req_i[6] = 1'b0; wait_cyc(5);
        check("R9 irq_o drops with level line", irq_o, 1'b0);
        check("R9 fiq_o drops with level line", fiq_o, 1'b0);
        bus_wr(3'd2, 16'h0020);
        chk_reg("R6 clear line 5", 3'd7, 16'h0000);
    endtask

    initial begin
        wait_cyc(4);
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(4);
        t_reset;
        t_setup;
        t_edge;
        t_level;
        t_masks;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule